// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers a set of level-sensitive interrupt request lines, latches them as pending, and offers one interrupt at a time to a processor. The processor accepts an offered interrupt with an acknowledge strobe and reads back which line was granted. When its handler finishes, it signals completion with an end-of-service strobe. The processor is expected to look at the request output only between instructions. The controller keeps no timing of its own around that.

A mode input selects one of two policies. In sequential mode only one handler may be active. Lines that arrive during that handler stay pending and are granted later in the order they arrived. In nested mode every line has a fixed rank, with line 0 the most urgent. A pending line preempts the handler in service only if its rank is strictly higher. The in-service set works as a stack: end of service retires the most urgent active level, so service falls back to the level that was interrupted.

The processor handshake follows valid/ready rules. `int_req` acts as valid and `int_ack` as ready. A grant takes place in a cycle where both are high. `int_ack` has no effect while `int_req` is low. Once raised, `int_req` stays high until the grant is accepted. In sequential mode `grant_id` also holds steady while it waits. In nested mode a more urgent arrival may replace the offered line before it is accepted.

Top module: `pic_nest_ctrl`

## Requirements
- R1: After reset no line is pending or in service and `int_req` is low.
- R2: A line that is high at a clock edge, and is neither pending nor in service, becomes pending at that edge. It stays pending after the line drops until it is granted.
- R3: In sequential mode (`nested_mode` = 0), `int_req` is low whenever any line is in service.
- R4: In sequential mode, pending lines are offered in arrival order. Lines that became pending at the same edge are ordered by index, with the lowest index first.
- R5: In nested mode (`nested_mode` = 1), `grant_id` is the lowest-index pending line. `int_req` is high when that index is below every in-service index, or when nothing is in service.
- R6: In nested mode, a pending line whose index is equal to or above the lowest in-service index does not raise `int_req`.
- R7: At an edge where `int_req` and `int_ack` are both high, the line on `grant_id` stops being pending and enters service. An `int_ack` while `int_req` is low changes nothing.
- R8: An `eoi` pulse removes the lowest-index in-service line from service, so service returns to the next level. An `eoi` with nothing in service has no effect.
- R9: A line that stays high while it is in service is not latched again. It becomes pending at the first edge after its service has ended.
- R10: In sequential mode, while `int_req` is high and no grant takes place, `int_req` and `grant_id` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| nested_mode | input | 1 | 0 = sequential arrival-order service, 1 = preemptive by rank |
| irq_in | input | 8 | Level-sensitive request lines, bit 0 most urgent |
| int_req | output | 1 | Interrupt offered to the processor (valid) |
| int_ack | input | 1 | Processor accepts the offered interrupt (ready) |
| grant_id | output | 3 | Index of the offered line, meaningful while int_req is high |
| eoi | input | 1 | End-of-service strobe from the handler |

## Verification
Several properties are checked on every cycle:
- no request is raised in sequential mode while a handler is active;
- the offered line is always pending;
- a pending line is never in service at the same time;
- the arrival queue always holds exactly the pending lines;
- a grant moves its line into service;
- end of service retires exactly one level;
- a waiting sequential offer stays stable.

Arrival order across several cycles, preemption and its refusal at equal or lower rank, and the return to an interrupted level can only be shown by the bench's scenarios. The same holds for re-latching of a line still held high after its service, and for stray acknowledge and end-of-service pulses.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int LINES_DEF = 8;
endpackage

// File: rtl/pic_lowest_set.sv
module pic_lowest_set #(
  parameter int N = pic_pkg::LINES_DEF,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] vec,
  output logic         any,
  output logic [W-1:0] idx
);
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = W'(i);
    end
  end
endmodule

// File: rtl/pic_arrival_queue.sv
module pic_arrival_queue #(
  parameter int N = pic_pkg::LINES_DEF,
  localparam int W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] arrive,
  input  logic         drop_en,
  input  logic [W-1:0] drop_id,
  output logic         head_valid,
  output logic [W-1:0] head_id,
  output logic [W:0]   occupancy
);
  logic [W-1:0] slot_q [N];
  logic [W-1:0] slot_d [N];
  logic [W:0]   cnt_q, cnt_d;

  always_comb begin
    logic [W:0] k;
    k = '0;
    for (int i = 0; i < N; i++) slot_d[i] = slot_q[i];
    // keep surviving entries in their order
    for (int i = 0; i < N; i++) begin
      if ((W+1)'(i) < cnt_q && !(drop_en && slot_q[i] == drop_id)) begin
        slot_d[k[W-1:0]] = slot_q[i];
        k = k + {{W{1'b0}}, 1'b1};
      end
    end
    // append this cycle's arrivals, lowest index first
    for (int j = 0; j < N; j++) begin
      if (arrive[j] && k < (W+1)'(N)) begin
        slot_d[k[W-1:0]] = W'(j);
        k = k + {{W{1'b0}}, 1'b1};
      end
    end
    cnt_d = k;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < N; i++) slot_q[i] <= '0;
    end else begin
      cnt_q <= cnt_d;
      for (int i = 0; i < N; i++) slot_q[i] <= slot_d[i];
    end
  end

  assign head_valid = (cnt_q != '0);
  assign head_id    = slot_q[0];
  assign occupancy  = cnt_q;

  a_r4_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= (W+1)'(N));
endmodule

// File: rtl/pic_service_track.sv
module pic_service_track #(
  parameter int N = pic_pkg::LINES_DEF,
  localparam int W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic [W-1:0] set_id,
  input  logic         retire,
  output logic [N-1:0] active
);
  logic [N-1:0] act_q, after_retire;

  // x & (x-1) drops the lowest-index set bit: the most urgent level
  assign after_retire = retire ? (act_q & (act_q - 1'b1)) : act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '0;
    else if (set_en) act_q <= after_retire | (N'(1) << set_id);
    else act_q <= after_retire;
  end

  assign active = act_q;

  // R8: one end-of-service removes exactly one level
  a_r8_retire_one: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !set_en && act_q != '0) |=>
      ($countones(act_q) == $countones($past(act_q)) - 1));

  // R8: end-of-service with nothing active leaves nothing active
  a_r8_retire_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !set_en && act_q == '0) |=> (act_q == '0));
endmodule

// File: rtl/pic_nest_ctrl.sv
module pic_nest_ctrl #(
  parameter int N = pic_pkg::LINES_DEF,
  localparam int W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         nested_mode,
  input  logic [N-1:0] irq_in,
  output logic         int_req,
  input  logic         int_ack,
  output logic [W-1:0] grant_id,
  input  logic         eoi
);
  logic [N-1:0] pend_q, pend_d, arrive, in_svc;
  logic         pend_any, svc_any, q_valid, accept;
  logic [W-1:0] pend_top, svc_top, q_head;
  logic [W:0]   q_occ;

  assign arrive = irq_in & ~pend_q & ~in_svc;
  assign accept = int_req & int_ack;

  always_comb begin
    pend_d = pend_q | arrive;
    if (accept) pend_d[grant_id] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else pend_q <= pend_d;
  end

  pic_lowest_set #(.N(N)) u_pend_rank (
    .vec(pend_q), .any(pend_any), .idx(pend_top));

  pic_lowest_set #(.N(N)) u_svc_rank (
    .vec(in_svc), .any(svc_any), .idx(svc_top));

  pic_arrival_queue #(.N(N)) u_order (
    .clk(clk), .rst_n(rst_n), .arrive(arrive),
    .drop_en(accept), .drop_id(grant_id),
    .head_valid(q_valid), .head_id(q_head), .occupancy(q_occ));

  pic_service_track #(.N(N)) u_svc (
    .clk(clk), .rst_n(rst_n), .set_en(accept), .set_id(grant_id),
    .retire(eoi), .active(in_svc));

  always_comb begin
    if (nested_mode) begin
      grant_id = pend_top;
      int_req  = pend_any && (!svc_any || pend_top < svc_top);
    end else begin
      grant_id = q_head;
      int_req  = q_valid && !svc_any;
    end
  end

  // R3: sequential mode never offers during an active handler
  a_r3_seq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!nested_mode && in_svc != '0) |-> !int_req);

  // R5: the offered line is always a pending one
  a_r5_offer_pending: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> pend_q[grant_id]);

  // R9: a line is never pending and in service together
  a_r9_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & in_svc) == '0);

  // R4: the order queue holds exactly the pending lines
  a_r4_queue_match: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pend_q) == int'(q_occ));

  // R7: an accepted line enters service and leaves pending
  a_r7_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (in_svc[$past(grant_id)] && !pend_q[$past(grant_id)]));

  // R10: a waiting sequential offer holds steady
  a_r10_seq_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!nested_mode && int_req && !int_ack) |=>
      (nested_mode || (int_req && $stable(grant_id))));
endmodule

// File: tb/sim_pic_nest_ctrl.sv
`timescale 1ns/1ps
module sim_pic_nest_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       nested_mode = 1'b0;
  logic [7:0] irq_in = '0;
  logic       int_req;
  logic       int_ack = 1'b0;
  logic [2:0] grant_id;
  logic       eoi = 1'b0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pic_nest_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .nested_mode(nested_mode), .irq_in(irq_in),
    .int_req(int_req), .int_ack(int_ack), .grant_id(grant_id), .eoi(eoi));

  // {mode, irq[7:0], ack, eoi, check_id, exp_req, exp_id[2:0]}
  localparam logic [15:0] VEC [11] = '{
    {1'b0, 8'h20, 1'b0, 1'b0, 1'b1, 1'b1, 3'd5}, // R2 line 5 arrives
    {1'b0, 8'h0A, 1'b0, 1'b0, 1'b1, 1'b1, 3'd5}, // R4 lines 1,3 queue behind 5
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0}, // R7 grant 5
    {1'b0, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0}, // R3 line 0 blocked
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 3'd1}, // R4 next in arrival order: 1
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0},
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 3'd3}, // R4 then 3
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0},
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 3'd0}, // R4 line 0 last despite rank
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0},
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0}  // R8 all retired
  };

  task automatic drive(input logic nm, input logic [7:0] ir,
                       input logic ak, input logic eo);
    @(negedge clk);
    nested_mode = nm; irq_in = ir; int_ack = ak; eoi = eo;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input string tag, input logic er,
                            input logic ci, input logic [2:0] ei);
    checks++;
    if (int_req !== er) begin
      fails++;
      $display("FAIL %s int_req actual=%b expected=%b", tag, int_req, er);
    end
    if (ci) begin
      checks++;
      if (grant_id !== ei) begin
        fails++;
        $display("FAIL %s grant_id actual=%0d expected=%0d", tag, grant_id, ei);
      end
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    expect_out("R1 in reset", 1'b0, 1'b0, 3'd0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(0, 8'h00, 0, 0);
    expect_out("R1 after reset", 1'b0, 1'b0, 3'd0);

    // table walk: sequential arrival ordering
    for (int v = 0; v < 11; v++) begin
      drive(VEC[v][15], VEC[v][14:7], VEC[v][6], VEC[v][5]);
      expect_out($sformatf("R4 vector %0d", v), VEC[v][3], VEC[v][4], VEC[v][2:0]);
    end

    // R9: line held high across its own service
    drive(0, 8'h08, 0, 0); expect_out("R9 first latch", 1'b1, 1'b1, 3'd3);
    drive(0, 8'h08, 1, 0); expect_out("R9 granted", 1'b0, 1'b0, 3'd0);
    drive(0, 8'h08, 0, 1); expect_out("R9 no relatch at eoi edge", 1'b0, 1'b0, 3'd0);
    drive(0, 8'h08, 0, 0); expect_out("R9 relatch after service", 1'b1, 1'b1, 3'd3);
    drive(0, 8'h00, 1, 0); expect_out("R9 second grant", 1'b0, 1'b0, 3'd0);
    drive(0, 8'h00, 0, 1); expect_out("R9 no duplicate", 1'b0, 1'b0, 3'd0);

    // R7: stray ack while idle must not put anything in service
    drive(0, 8'h00, 1, 0); expect_out("R7 stray ack", 1'b0, 1'b0, 3'd0);
    drive(0, 8'h80, 0, 0); expect_out("R7 ack ignored", 1'b1, 1'b1, 3'd7);
    drive(0, 8'h00, 1, 0);
    drive(0, 8'h00, 0, 1);

    // R2: single-cycle pulse stays pending; R10 offer stable while waiting
    drive(0, 8'h20, 0, 0); expect_out("R2 pulse latched", 1'b1, 1'b1, 3'd5);
    drive(0, 8'h00, 0, 0);
    drive(0, 8'h00, 0, 0);
    drive(0, 8'h00, 0, 0); expect_out("R10 offer held", 1'b1, 1'b1, 3'd5);
    drive(0, 8'h00, 1, 0);
    drive(0, 8'h00, 0, 1);

    // nested mode: preemption and return
    drive(1, 8'h10, 0, 0); expect_out("R5 line 4 offered", 1'b1, 1'b1, 3'd4);
    drive(1, 8'h00, 1, 0); expect_out("R7 line 4 in service", 1'b0, 1'b0, 3'd0);
    drive(1, 8'h40, 0, 0); expect_out("R6 lower rank waits", 1'b0, 1'b0, 3'd0);
    drive(1, 8'h10, 0, 0); expect_out("R6 equal rank waits", 1'b0, 1'b0, 3'd0);
    drive(1, 8'h04, 0, 0); expect_out("R5 line 2 preempts", 1'b1, 1'b1, 3'd2);
    drive(1, 8'h00, 1, 0); expect_out("R5 nested grant", 1'b0, 1'b0, 3'd0);
    drive(1, 8'h00, 0, 1); expect_out("R8 back at level 4", 1'b0, 1'b0, 3'd0);
    drive(1, 8'h08, 0, 0); expect_out("R8 level 4 still preemptible", 1'b1, 1'b1, 3'd3);
    drive(1, 8'h00, 1, 0);
    drive(1, 8'h00, 0, 1); expect_out("R8 return to 4", 1'b0, 1'b0, 3'd0);
    drive(1, 8'h00, 0, 1); expect_out("R8 line 6 after all retired", 1'b1, 1'b1, 3'd6);
    drive(1, 8'h00, 1, 0);
    drive(1, 8'h00, 0, 1);
    drive(1, 8'h00, 0, 1); expect_out("R8 eoi when idle", 1'b0, 1'b0, 3'd0);
    drive(1, 8'h81, 0, 0); expect_out("R5 lowest index wins", 1'b1, 1'b1, 3'd0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule